// File: doc/BRIEF.md
# Thermostat Alert Engine with Fault Queue

This block takes each finished 12-bit temperature conversion and compares it, as a signed two's complement value in 1/16 °C steps, with a high and a low threshold. It drives three outputs: a status bit, an alert output whose active level is selectable, and a cause bit for an alert-response transaction. A programmable fault queue filters noise. The alert state changes only after 1, 2, 4 or 6 faulting conversions in a row.

The block has two modes. In comparator mode the alert follows a hysteresis state. The state sets at or above the high threshold and releases only below the low threshold. In interrupt mode the alert is an event latch. It sets on a threshold crossing and stays set until a register read, a won alert-response arbitration or shutdown clears it. After each clear the block watches the other threshold. The surrounding serial-bus logic writes the thresholds and configuration through a simple write port. It reports reads, alert-response wins, shutdown and general-call resets as strobes or levels.

Top module: `tstat_alert`

## Requirements
- R1: The queue field (write data bits 3:2 of a config write) selects 1, 2, 4 or 6 faulting conversions for codes 0, 1, 2 and 3. A conversion that does not fault restarts the count.
- R2: In comparator mode, the comparator state becomes active when the temperature is greater than or equal to the high threshold for the selected number of consecutive conversions.
- R3: Once active, the comparator state returns to inactive only when the temperature is below the low threshold for the selected number of consecutive conversions. Temperatures between the thresholds leave it unchanged.
- R4: The status output reflects the comparator state in either mode. With polarity 0 it is 1 when inactive and 0 when active. Polarity 1 inverts it.
- R5: The alert output is active low with polarity 0 and active high with polarity 1. In comparator mode it follows the comparator state.
- R6: In interrupt mode the alert becomes active after the selected number of consecutive faults. It stays active until a read strobe, an alert-response win or the shutdown level clears it.
- R7: In interrupt mode the watched threshold alternates. The block starts on the high threshold (at or above), switches to the low threshold (below) after a clear, and switches back after the next clear.
- R8: The cause output is 0 for an alert raised by the high threshold and 1 for one raised by the low threshold, XOR the polarity bit.
- R9: All 12 bits of the temperature and of both thresholds are compared as signed values.
- R10: Reset and the general-call reset input set the high threshold to 0x500, the low threshold to 0x4B0, comparator mode, polarity 0 and queue code 0, and clear every alert state.
- R11: The write select codes are 0 for config (bit 0 mode, 1 = interrupt; bit 1 polarity), 1 for the low threshold and 2 for the high threshold. Code 3 has no effect. A write with code 0 to 2 restarts both fault counts, and the conversion in that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: temp_in holds a new result |
| temp_in | input | 12 | Conversion result, signed, 1/16 °C per LSB |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 low, 2 high, 3 none |
| wr_data | input | 12 | Write data |
| rd_strobe | input | 1 | Any register was read |
| ara_win | input | 1 | Alert-response arbitration won |
| shutdown | input | 1 | Shutdown state level |
| gc_reset | input | 1 | General-call reset strobe |
| alert_o | output | 1 | Alert output, level per polarity |
| status_o | output | 1 | Comparator status bit |
| ara_bit_o | output | 1 | Alert cause bit for the response byte |

## Verification
The hardest states to reach are the interrupt-mode ones. The second half of the threshold alternation exists only after a set-and-clear round trip, and a fault count that a write or a cool conversion interrupts leaves no trace at the outputs. The stimulus therefore walks the interrupt latch through every clear source in turn: read, alert-response win and shutdown. At each step it sends temperatures that would trip the other threshold. It also sends one conversion short of the queue depth before each write or non-faulting sample, so that an early alert would expose a counter that was not restarted.

// File: rtl/tstat_pkg.sv
`timescale 1ns/1ps
package tstat_pkg;
  typedef struct packed {
    logic       intr_mode;
    logic       pol;
    logic [1:0] queue;
  } tcfg_t;

  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_LO  = 2'd1;
  localparam logic [1:0] SEL_HI  = 2'd2;

  // queue code to number of consecutive faults
  function automatic logic [2:0] queue_depth(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/tstat_regs.sv
`timescale 1ns/1ps
module tstat_regs
  import tstat_pkg::*;
#(
  parameter int TW = 12,
  parameter logic [TW-1:0] HI_RST = 12'h500,
  parameter logic [TW-1:0] LO_RST = 12'h4B0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gc_reset,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  output logic [TW-1:0] hi_lim,
  output logic [TW-1:0] lo_lim,
  output tcfg_t         cfg,
  output logic          upd
);
  assign upd = wr_en && (wr_sel != 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_lim <= HI_RST;
      lo_lim <= LO_RST;
      cfg    <= '0;
    end else if (gc_reset) begin
      hi_lim <= HI_RST;
      lo_lim <= LO_RST;
      cfg    <= '0;
    end else if (upd) begin
      case (wr_sel)
        SEL_CFG: cfg <= '{intr_mode: wr_data[0], pol: wr_data[1], queue: wr_data[3:2]};
        SEL_LO:  lo_lim <= wr_data;
        SEL_HI:  hi_lim <= wr_data;
        default: ;
      endcase
    end
  end

  // R10: a general-call reset restores the default thresholds
  a_r10_gc_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (hi_lim == HI_RST) && (lo_lim == LO_RST) && (cfg == '0));
endmodule

// File: rtl/tstat_fault_ctr.sv
`timescale 1ns/1ps
module tstat_fault_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          cond,
  input  logic [CW-1:0] need,
  output logic          hit,
  output logic [CW-1:0] cnt
);
  logic [CW:0] cnt_inc;
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign hit     = step && cond && !clr && (cnt_inc >= {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || hit) cnt <= '0;
    else if (step)       cnt <= cond ? cnt_inc[CW-1:0] : '0;
  end

  // R1: the stored run never reaches the depth; reaching it fires hit instead
  a_r1_count_below_need: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < need);
  // R1: a conversion without a fault restarts the run
  a_r1_miss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cond) |=> (cnt == '0));
endmodule

// File: rtl/tstat_alert.sv
`timescale 1ns/1ps
module tstat_alert
  import tstat_pkg::*;
#(
  parameter int TW = 12,
  parameter logic [TW-1:0] HI_RST = 12'h500,
  parameter logic [TW-1:0] LO_RST = 12'h4B0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [TW-1:0] temp_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [TW-1:0] wr_data,
  input  logic          rd_strobe,
  input  logic          ara_win,
  input  logic          shutdown,
  input  logic          gc_reset,
  output logic          alert_o,
  output logic          status_o,
  output logic          ara_bit_o
);
  localparam int QW = 3;

  function automatic logic sgn_ge(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  logic [TW-1:0] hi_lim, lo_lim;
  tcfg_t         cfg;
  logic          upd;

  tstat_regs #(.TW(TW), .HI_RST(HI_RST), .LO_RST(LO_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .hi_lim(hi_lim), .lo_lim(lo_lim),
    .cfg(cfg), .upd(upd)
  );

  // named events for assertions
  logic          hi_hit, lo_hit, clr_evt, conv_ok;
  logic [QW-1:0] need;
  assign hi_hit  = sgn_ge(temp_in, hi_lim);
  assign lo_hit  = !sgn_ge(temp_in, lo_lim);
  assign clr_evt = rd_strobe || shutdown || ara_win;
  assign conv_ok = conv_done && !upd && !gc_reset;
  assign need    = queue_depth(cfg.queue);

  // comparator tracker
  logic          cmp_act, cmp_hit;
  logic [QW-1:0] cmp_cnt;
  tstat_fault_ctr #(.CW(QW)) u_cmp_ctr (
    .clk(clk), .rst_n(rst_n), .clr(gc_reset || upd), .step(conv_ok),
    .cond(cmp_act ? lo_hit : hi_hit), .need(need), .hit(cmp_hit), .cnt(cmp_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_act <= 1'b0;
    else if (gc_reset) cmp_act <= 1'b0;
    else if (cmp_hit)  cmp_act <= !cmp_act;
  end

  // interrupt tracker
  logic          int_pend, int_seek_lo, int_cause, int_hit, mode_off;
  logic [QW-1:0] int_cnt;
  assign mode_off = upd && (wr_sel == SEL_CFG) && !wr_data[0];

  tstat_fault_ctr #(.CW(QW)) u_int_ctr (
    .clk(clk), .rst_n(rst_n),
    .clr(gc_reset || upd || clr_evt || int_pend || !cfg.intr_mode),
    .step(conv_ok), .cond(int_seek_lo ? lo_hit : hi_hit), .need(need),
    .hit(int_hit), .cnt(int_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_pend <= 1'b0; int_seek_lo <= 1'b0; int_cause <= 1'b0;
    end else if (gc_reset || mode_off) begin
      int_pend <= 1'b0; int_seek_lo <= 1'b0; int_cause <= gc_reset ? 1'b0 : int_cause;
    end else if (cfg.intr_mode) begin
      if (clr_evt && int_pend) begin
        int_pend    <= 1'b0;
        int_seek_lo <= !int_seek_lo;
      end else if (int_hit) begin
        int_pend  <= 1'b1;
        int_cause <= int_seek_lo;
      end
    end
  end

  logic act;
  assign act       = cfg.intr_mode ? int_pend : cmp_act;
  assign alert_o   = cfg.pol ? act : !act;
  assign status_o  = cfg.pol ? cmp_act : !cmp_act;
  assign ara_bit_o = int_cause ^ cfg.pol;

  // R2: the comparator state only rises on a conversion
  a_r2_rise_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_act) |-> $past(conv_done) && $past(hi_hit));
  // R3: the comparator state only falls on a low conversion or general call
  a_r3_fall_on_conv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_act) |-> ($past(conv_done) && $past(lo_hit)) || $past(gc_reset));
  // R6: interrupt latch sets only from a conversion in interrupt mode
  a_r6_int_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pend) |-> $past(conv_done) && $past(cfg.intr_mode));
  // R6: any clear source drops the latch
  a_r6_int_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && clr_evt) |=> !int_pend);
  // R7: the watched threshold flips only on a clear of a pending alert
  a_r7_seek_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (int_seek_lo != $past(int_seek_lo)) |->
      $past(int_pend) || $past(gc_reset) || $past(mode_off));
endmodule

// File: tb/tstat_alert_tb.sv
`timescale 1ns/1ps
module tstat_alert_tb;
  logic clk = 1'b0;
  always #2.5 clk = !clk;

  logic        rst_n = 1'b0;
  logic        conv_done = 0, wr_en = 0, rd_strobe = 0, ara_win = 0, shutdown = 0, gc_reset = 0;
  logic [11:0] temp_in = '0, wr_data = '0;
  logic [1:0]  wr_sel = '0;
  logic        alert_o, status_o, ara_bit_o;

  tstat_alert u_dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp_in(temp_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .ara_win(ara_win), .shutdown(shutdown), .gc_reset(gc_reset),
    .alert_o(alert_o), .status_o(status_o), .ara_bit_o(ara_bit_o)
  );

  int checks = 0, fails = 0;
  string cur_req = "R10";

  // behavioural reference
  int m_hi, m_lo, m_mode, m_pol, m_q, m_cmp, m_ccnt, m_ip, m_seek, m_icnt, m_cause;
  int qd[4] = '{1, 2, 4, 6};

  function automatic int sx(input logic [11:0] v);
    return v[11] ? int'(v) - 4096 : int'(v);
  endfunction

  task automatic model_defaults();
    m_hi = 1280; m_lo = 1200; m_mode = 0; m_pol = 0; m_q = 0;
    m_cmp = 0; m_ccnt = 0; m_ip = 0; m_seek = 0; m_icnt = 0; m_cause = 0;
  endtask

  task automatic model_step();
    int t, depth;
    bit vw, ev, c;
    if (!rst_n || gc_reset) begin model_defaults(); return; end
    t = sx(temp_in); depth = qd[m_q];
    vw = wr_en && (wr_sel != 2'd3);
    ev = rd_strobe || shutdown || ara_win;
    if (vw) m_ccnt = 0;
    else if (conv_done) begin
      c = m_cmp ? (t < m_lo) : (t >= m_hi);
      if (!c) m_ccnt = 0;
      else begin
        m_ccnt++;
        if (m_ccnt >= depth) begin m_cmp = !m_cmp; m_ccnt = 0; end
      end
    end
    if (vw && wr_sel == 2'd0 && !wr_data[0]) begin m_ip = 0; m_seek = 0; m_icnt = 0; end
    else if (m_mode == 0) m_icnt = 0;
    else if (ev) begin
      if (m_ip) begin m_ip = 0; m_seek = !m_seek; end
      m_icnt = 0;
    end else if (vw) m_icnt = 0;
    else if (conv_done && !m_ip) begin
      c = m_seek ? (t < m_lo) : (t >= m_hi);
      if (!c) m_icnt = 0;
      else begin
        m_icnt++;
        if (m_icnt >= depth) begin m_ip = 1; m_cause = m_seek; m_icnt = 0; end
      end
    end
    if (vw) case (wr_sel)
      2'd0: begin m_mode = wr_data[0]; m_pol = wr_data[1]; m_q = wr_data[3:2]; end
      2'd1: m_lo = sx(wr_data);
      2'd2: m_hi = sx(wr_data);
      default: ;
    endcase
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic compare();
    int a;
    a = m_mode ? m_ip : m_cmp;
    chk(alert_o,   m_pol ? a[0] : !a[0], cur_req, "alert_o");
    chk(status_o,  m_pol ? m_cmp[0] : !m_cmp[0], cur_req, "status_o");
    chk(ara_bit_o, m_cause[0] ^ m_pol[0], cur_req, "ara_bit_o");
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  task automatic conv(input logic [11:0] t);
    temp_in = t; conv_done = 1; cyc(); conv_done = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [11:0] d);
    wr_sel = s; wr_data = d; wr_en = 1; cyc(); wr_en = 0;
  endtask

  task automatic pulse_rd();  rd_strobe = 1; cyc(); rd_strobe = 0; endtask
  task automatic pulse_ara(); ara_win = 1;   cyc(); ara_win = 0;   endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_defaults();
    cur_req = "R10";
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk(alert_o, 1'b1, "R10", "reset alert idle high");
    chk(status_o, 1'b1, "R10", "reset status");

    // R2 / R3 comparator with default thresholds, depth 1
    cur_req = "R2";
    conv(12'h4FF); chk(alert_o, 1'b1, "R2", "just below high");
    conv(12'h500); chk(alert_o, 1'b0, "R2", "at high threshold");
    cur_req = "R3";
    conv(12'h4C0); chk(alert_o, 1'b0, "R3", "inside hysteresis band");
    conv(12'h4B0); chk(alert_o, 1'b0, "R3", "equal to low stays");
    conv(12'h4AF); chk(alert_o, 1'b1, "R3", "below low releases");

    // R1 queue depths
    cur_req = "R1";
    wr(2'd0, 12'h008);                 // depth 4
    repeat (3) conv(12'h600);
    conv(12'h100);                     // miss restarts
    repeat (3) conv(12'h600);
    chk(alert_o, 1'b1, "R1", "three after miss not enough");
    conv(12'h600); chk(alert_o, 1'b0, "R1", "fourth fault sets");
    wr(2'd0, 12'h00C);                 // depth 6
    repeat (5) conv(12'h000);
    chk(alert_o, 1'b0, "R1", "five lows with depth 6");
    conv(12'h000); chk(alert_o, 1'b1, "R1", "sixth low clears");
    wr(2'd0, 12'h004);                 // depth 2
    conv(12'h700); chk(alert_o, 1'b1, "R1", "one of two");
    conv(12'h700); chk(alert_o, 1'b0, "R1", "two of two");

    // R4 / R5 polarity and mode independence of status
    cur_req = "R5";
    wr(2'd0, 12'h002);
    chk(alert_o, 1'b1, "R5", "pol1 active high");
    chk(status_o, 1'b1, "R4", "pol1 status inverted");
    cur_req = "R4";
    wr(2'd0, 12'h001);                 // interrupt mode, pol 0
    chk(status_o, 1'b0, "R4", "status follows comparator in interrupt mode");
    wr(2'd0, 12'h000);
    conv(12'h000);

    // R9 signed thresholds
    cur_req = "R9";
    wr(2'd1, 12'hE70);                 // -25
    wr(2'd2, 12'h004);                 // +0.25
    conv(12'hFFC); chk(alert_o, 1'b1, "R9", "-0.25 below +0.25");
    conv(12'h190); chk(alert_o, 1'b0, "R9", "+25 above high");
    conv(12'hE80); chk(alert_o, 1'b0, "R9", "-24 above -25");
    conv(12'hC90); chk(alert_o, 1'b1, "R9", "-55 below low");
    wr(2'd1, 12'h4B0); wr(2'd2, 12'h500);

    // R6 / R7 / R8 interrupt mode
    cur_req = "R6";
    wr(2'd0, 12'h001);
    conv(12'h600); chk(alert_o, 1'b0, "R6", "interrupt set");
    chk(ara_bit_o, 1'b0, "R8", "high cause");
    conv(12'h000); chk(alert_o, 1'b0, "R6", "held without clear");
    pulse_rd(); chk(alert_o, 1'b1, "R6", "read clears");
    cur_req = "R7";
    conv(12'h600); chk(alert_o, 1'b1, "R7", "high ignored while seeking low");
    conv(12'h000); chk(alert_o, 1'b0, "R7", "low triggers");
    chk(ara_bit_o, 1'b1, "R8", "low cause");
    pulse_ara(); chk(alert_o, 1'b1, "R6", "ara win clears");
    conv(12'h000); chk(alert_o, 1'b1, "R7", "low ignored while seeking high");
    conv(12'h600); chk(alert_o, 1'b0, "R7", "high again");
    shutdown = 1; cyc(); shutdown = 0;
    chk(alert_o, 1'b1, "R6", "shutdown clears");
    cur_req = "R8";
    wr(2'd0, 12'h003);                 // interrupt, pol 1
    conv(12'h000); chk(alert_o, 1'b1, "R8", "pol1 active");
    chk(ara_bit_o, 1'b0, "R8", "low cause inverted");
    pulse_rd();

    // R11 writes restart counts, select 3 ignored
    cur_req = "R11";
    wr(2'd0, 12'h008);                 // comparator, depth 4
    conv(12'h000);
    repeat (3) conv(12'h600);
    wr(2'd2, 12'h500);
    conv(12'h600); chk(alert_o, 1'b1, "R11", "write restarted run");
    conv(12'h600); conv(12'h600);
    wr(2'd3, 12'hFFF);
    conv(12'h600); chk(alert_o, 1'b0, "R11", "select 3 no effect");

    // R10 general call
    cur_req = "R10";
    wr(2'd2, 12'h7F0);
    gc_reset = 1; cyc(); gc_reset = 0;
    chk(alert_o, 1'b1, "R10", "gc clears alert");
    conv(12'h500); chk(alert_o, 1'b0, "R10", "default high and depth 1");
    conv(12'h4AF); chk(alert_o, 1'b1, "R10", "default low");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule